// File: doc/BRIEF.md
# Reverse-Channel Turnaround and Byte Transmitter

This block sits on the peripheral side of a half-duplex, byte-wide parallel link and moves bytes from the peripheral to the host. Local logic hands it bytes, each marked as either payload or command. The bytes wait in a small queue. While the queue holds anything, the block pulls its request line low to tell the host that there is something to read.

The host turns the link around by lowering its reverse-request line. The block answers on a grant line that follows that request, low meaning granted. Only after the grant does it enable its bus drivers. Each byte then goes out with a four-phase handshake:

1. The block places the byte and its type flag on the bus.
2. It lowers its strobe.
3. It waits until the host raises its acknowledge, then raises the strobe.
4. It waits until the host lowers the acknowledge before it starts the next byte.

If the host withdraws its request at any point, the block stops at once. It releases the strobe and disables the drivers, and only then raises the grant line to return to the forward direction. A byte that was already on the bus when the request was withdrawn is dropped. The bytes still queued behind it are kept.

The host-side inputs are asynchronous, and each passes through a synchronizer before the control logic uses it. The actual tri-state pads lie outside the block: they are controlled by `bus_out` and `bus_oe`.

Top module: `revch_top`

## Requirements
- R1: After reset, `periph_req_n`=1, `rev_grant_n`=1, `periph_strobe_n`=1, `bus_oe`=0 and `tx_ready`=1.
- R2: `periph_req_n` is 0 whenever at least one byte is queued and not yet taken for transmission, and 1 when the queue is empty.
- R3: `rev_grant_n` goes low after the host drives `host_rev_req_n` low, and returns high after the host drives it high again.
- R4: `bus_oe` is 1 only while `rev_grant_n` is 0. It rises at least one cycle after `rev_grant_n` falls, and falls at least one cycle before `rev_grant_n` rises.
- R5: A byte's strobe falls only while the bus is enabled. It stays low until `host_ack`=1 is seen, then rises. The next strobe comes only after `host_ack` has returned to 0.
- R6: `periph_flag` is 1 for a payload byte (`tx_cmd`=0) and 0 for a command byte (`tx_cmd`=1). The byte value appears unchanged on `bus_out`.
- R7: Bytes are transmitted in the order they were accepted.
- R8: The queue holds `FIFO_DEPTH` bytes. `tx_ready` is 0 when the queue is full, and a byte offered while `tx_ready`=0 is ignored and never transmitted.
- R9: While the link is in the forward direction, `host_ack` has no effect: `periph_strobe_n` stays 1 and `bus_oe` stays 0.
- R10: If the host raises `host_rev_req_n` during a transfer, the strobe returns to 1, the bus is disabled and the grant is withdrawn. The byte in flight is discarded, and the next grant starts with the following queued byte.
- R11: `bus_out` and `periph_flag` hold steady for the whole time the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Local logic offers a byte |
| tx_data | input | 8 | Byte offered |
| tx_cmd | input | 1 | 1 marks the offered byte as a command |
| tx_ready | output | 1 | Queue has room; an offer is taken when valid and ready |
| host_rev_req_n | input | 1 | Host reverse-direction request, active low, asynchronous |
| host_ack | input | 1 | Host acknowledge for reverse handshake, asynchronous |
| periph_req_n | output | 1 | Low while reverse data is waiting |
| rev_grant_n | output | 1 | Low while the reverse direction is granted |
| periph_strobe_n | output | 1 | Low while a valid byte is on the bus |
| periph_flag | output | 1 | 1 payload, 0 command, valid with the strobe |
| bus_out | output | 8 | Byte driven toward the host |
| bus_oe | output | 1 | Output enable for the bus drivers |

## Verification
The assertions assume that the host follows the handshake: it raises `host_ack` only after it sees the strobe low, and lowers it only after it sees the strobe high. They also assume that it keeps `host_ack` low when it grants the reverse direction. The bench plays the host this way. It changes its lines only on falling clock edges, and it reacts only to strobe levels it has sampled. Abort cases are produced by withdrawing the request while `host_ack` is still 0, which keeps the acknowledge within those assumptions. A sweep over all 512 pairs of byte value and command flag, fed through the queue under back-pressure, covers the data path completely.

// File: rtl/revch_pkg.sv
package revch_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              cmd;
        logic [DATA_W-1:0] data;
    } rev_item_t;

    typedef enum logic [2:0] {
        ST_FWD,
        ST_TURN,
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RELEASE
    } rev_state_e;

    // Bus drivers are on only in states strictly inside the granted window.
    function automatic logic drives_bus(rev_state_e st);
        return (st == ST_IDLE) || (st == ST_SETUP) ||
               (st == ST_STROBE) || (st == ST_HOLD);
    endfunction

    // Line level for the type flag: high for payload, low for command.
    function automatic logic flag_level(rev_item_t it);
        return ~it.cmd;
    endfunction

endpackage

// File: rtl/revch_sync.sv
module revch_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= RST_VAL;
                else     pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/revch_fifo.sv
module revch_fifo
    import revch_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rev_item_t din,
    input  logic      pop,
    output rev_item_t dout,
    output logic      empty,
    output logic      full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rev_item_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/revch_fsm.sv
module revch_fsm
    import revch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_n_s,
    input  logic              ack_s,
    input  rev_item_t         head,
    input  logic              empty,
    output logic              pop,
    output logic              grant_n,
    output logic              strobe_n,
    output logic              oe,
    output logic [DATA_W-1:0] bus_q,
    output logic              flag_q
);

    rev_state_e state, state_nx;
    logic       released;

    assign released = req_n_s;

    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            ST_FWD:     if (!released) state_nx = ST_TURN;
            ST_TURN:    state_nx = released ? ST_RELEASE : ST_IDLE;
            ST_IDLE: begin
                if (released) begin
                    state_nx = ST_RELEASE;
                end else if (!empty) begin
                    state_nx = ST_SETUP;
                    pop      = 1'b1;
                end
            end
            ST_SETUP:   state_nx = released ? ST_RELEASE : ST_STROBE;
            ST_STROBE: begin
                if (released)   state_nx = ST_RELEASE;
                else if (ack_s) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (released)    state_nx = ST_RELEASE;
                else if (!ack_s) state_nx = ST_IDLE;
            end
            ST_RELEASE: state_nx = ST_FWD;
            default:    state_nx = ST_FWD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FWD;
            bus_q  <= '0;
            flag_q <= 1'b1;
        end else begin
            state <= state_nx;
            if (pop) begin
                bus_q  <= head.data;
                flag_q <= flag_level(head);
            end
        end
    end

    assign grant_n  = (state == ST_FWD);
    assign strobe_n = (state != ST_STROBE);
    assign oe       = drives_bus(state);

endmodule

// File: rtl/revch_top.sv
module revch_top
    import revch_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_cmd,
    output logic       tx_ready,
    input  logic       host_rev_req_n,
    input  logic       host_ack,
    output logic       periph_req_n,
    output logic       rev_grant_n,
    output logic       periph_strobe_n,
    output logic       periph_flag,
    output logic [7:0] bus_out,
    output logic       bus_oe
);

    logic [1:0] host_raw, host_s;
    rev_item_t  in_item, head;
    logic       q_empty, q_full, q_pop;

    assign host_raw = {host_rev_req_n, host_ack};
    assign in_item  = '{cmd: tx_cmd, data: tx_data};
    assign tx_ready = !q_full;
    assign periph_req_n = q_empty;

    revch_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (host_raw),
        .q  (host_s)
    );

    revch_fifo #(
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (tx_valid),
        .din  (in_item),
        .pop  (q_pop),
        .dout (head),
        .empty(q_empty),
        .full (q_full)
    );

    revch_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_n_s (host_s[1]),
        .ack_s   (host_s[0]),
        .head    (head),
        .empty   (q_empty),
        .pop     (q_pop),
        .grant_n (rev_grant_n),
        .strobe_n(periph_strobe_n),
        .oe      (bus_oe),
        .bus_q   (bus_out),
        .flag_q  (periph_flag)
    );

endmodule

// File: rtl/revch_checker.sv
module revch_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       periph_req_n,
    input logic       rev_grant_n,
    input logic       periph_strobe_n,
    input logic       periph_flag,
    input logic [7:0] bus_out,
    input logic       bus_oe
);

    AST_OE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !rev_grant_n); // R4

    AST_OE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> !$past(rev_grant_n)); // R4

    AST_GRANT_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        $rose(rev_grant_n) |-> !$past(bus_oe)); // R4

    AST_STROBE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        !periph_strobe_n |-> bus_oe); // R5

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!periph_strobe_n && !$past(periph_strobe_n)) |->
            ($stable(bus_out) && $stable(periph_flag))); // R11

    AST_REQ_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !periph_req_n); // R2

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !tx_ready |-> !periph_req_n); // R8

    AST_FWD_QUIET: assert property (@(posedge clk) disable iff (rst)
        rev_grant_n |-> periph_strobe_n); // R9

endmodule

bind revch_top revch_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .periph_req_n   (periph_req_n),
    .rev_grant_n    (rev_grant_n),
    .periph_strobe_n(periph_strobe_n),
    .periph_flag    (periph_flag),
    .bus_out        (bus_out),
    .bus_oe         (bus_oe)
);

// File: tb/revch_top_bench.sv
`timescale 1ns/1ps
module revch_top_bench;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_cmd = 1'b0;
    logic       tx_ready;
    logic       host_rev_req_n = 1'b1;
    logic       host_ack = 1'b0;
    logic       periph_req_n, rev_grant_n, periph_strobe_n, periph_flag, bus_oe;
    logic [7:0] bus_out;

    int checks = 0;
    int errors = 0;
    int order_viol = 0;
    logic prev_oe = 1'b0, prev_grant_n = 1'b1;

    always #2 clk = ~clk;

    revch_top #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) u_revch_top (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_cmd(tx_cmd), .tx_ready(tx_ready),
        .host_rev_req_n(host_rev_req_n), .host_ack(host_ack),
        .periph_req_n(periph_req_n), .rev_grant_n(rev_grant_n),
        .periph_strobe_n(periph_strobe_n), .periph_flag(periph_flag),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    // R4 ordering monitor at falling edges
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_oe && rev_grant_n) order_viol++;
            if (rev_grant_n && !prev_grant_n && prev_oe) order_viol++;
            if (bus_oe && !prev_oe && prev_grant_n) order_viol++;
        end
        prev_oe      <= bus_oe;
        prev_grant_n <= rev_grant_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic wait_strobe(input logic lvl, output bit ok);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (periph_strobe_n == lvl) begin ok = 1; break; end
        end
    endtask

    task automatic wait_grant(input logic lvl, output bit ok);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rev_grant_n == lvl) begin ok = 1; break; end
        end
    endtask

    // Host side of one reverse byte handshake
    task automatic host_take(input int exp_d, input logic exp_f, input string req);
        bit ok;
        logic [7:0] d0;
        logic f0;
        wait_strobe(1'b0, ok);
        chk(ok, "R5", "strobe fall", periph_strobe_n, 0);
        chk(bus_out == exp_d[7:0], req, "bus_out", bus_out, exp_d);
        chk(periph_flag == exp_f, "R6", "flag", periph_flag, exp_f);
        chk(bus_oe == 1'b1, "R5", "oe with strobe", bus_oe, 1);
        d0 = bus_out;
        f0 = periph_flag;
        repeat (3) @(negedge clk);
        chk(periph_strobe_n == 1'b0, "R5", "strobe held without ack", periph_strobe_n, 0);
        chk(bus_out == d0 && periph_flag == f0, "R11", "bus steady", bus_out, d0);
        host_ack = 1'b1;
        wait_strobe(1'b1, ok);
        chk(ok, "R5", "strobe rise after ack", periph_strobe_n, 1);
        repeat (2) @(negedge clk);
        chk(periph_strobe_n == 1'b1, "R5", "no strobe while ack high", periph_strobe_n, 1);
        host_ack = 1'b0;
    endtask

    // Offer one item per cycle regardless of ready
    task automatic force_push(input logic [7:0] d, input logic c);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_cmd = c;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Sweep producer honouring tx_ready: item i = {cmd=i[8], data=i[7:0]}
    task automatic produce(input int n);
        int idx = 0;
        while (idx < n) begin
            @(negedge clk);
            if (tx_valid) idx++;
            if (idx < n && tx_ready) begin
                tx_valid = 1'b1;
                tx_data  = idx[7:0];
                tx_cmd   = idx[8];
            end else begin
                tx_valid = 1'b0;
            end
        end
        tx_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(periph_req_n == 1'b1, "R1", "req_n", periph_req_n, 1);
        chk(rev_grant_n == 1'b1, "R1", "grant_n", rev_grant_n, 1);
        chk(periph_strobe_n == 1'b1, "R1", "strobe_n", periph_strobe_n, 1);
        chk(bus_oe == 1'b0, "R1", "oe", bus_oe, 0);
        chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);

        // R9: host_ack wiggled in forward direction
        for (int i = 0; i < 12; i++) begin
            host_ack = i[0];
            @(negedge clk);
            chk(periph_strobe_n == 1'b1 && bus_oe == 1'b0, "R9", "forward quiet",
                {periph_strobe_n, bus_oe}, 2);
        end
        host_ack = 1'b0;
        repeat (4) @(negedge clk);

        // R8: fill past depth, extra item must vanish
        for (int i = 0; i <= DEPTH; i++) begin
            force_push(8'h11 + 8'(i), 1'b0);
            if (i == 0) chk(periph_req_n == 1'b0, "R2", "req after push", periph_req_n, 0);
            if (i == DEPTH - 1) chk(tx_ready == 1'b0, "R8", "full", tx_ready, 0);
        end
        host_rev_req_n = 1'b0;
        wait_grant(1'b0, ok);
        chk(ok, "R3", "grant low", rev_grant_n, 0);
        chk(bus_oe == 1'b0, "R4", "oe after grant", bus_oe, 0);
        for (int i = 0; i < DEPTH; i++) host_take(8'h11 + i, 1'b1, "R7");
        ok = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!periph_strobe_n) ok = 0;
        end
        chk(ok, "R8", "dropped item not sent", ok, 1);
        chk(periph_req_n == 1'b1, "R2", "req released when empty", periph_req_n, 1);

        // Full sweep of value x type under back-pressure (R6, R7)
        fork
            produce(512);
            begin
                for (int i = 0; i < 512; i++)
                    host_take(i & 255, ~i[8], "R7");
            end
        join
        host_rev_req_n = 1'b1;
        wait_grant(1'b1, ok);
        chk(ok, "R3", "grant returns high", rev_grant_n, 1);
        chk(bus_oe == 1'b0, "R4", "oe off after release", bus_oe, 0);

        // R10: abort mid-transfer
        force_push(8'hA5, 1'b0);
        force_push(8'h3C, 1'b1);
        host_rev_req_n = 1'b0;
        wait_strobe(1'b0, ok);
        chk(ok && bus_out == 8'hA5, "R10", "first byte on bus", bus_out, 8'hA5);
        host_rev_req_n = 1'b1;
        wait_grant(1'b1, ok);
        chk(ok, "R10", "grant withdrawn", rev_grant_n, 1);
        chk(periph_strobe_n == 1'b1, "R10", "strobe released", periph_strobe_n, 1);
        chk(bus_oe == 1'b0, "R10", "bus disabled", bus_oe, 0);
        chk(periph_req_n == 1'b0, "R10", "remaining byte kept", periph_req_n, 0);
        host_rev_req_n = 1'b0;
        host_take(8'h3C, 1'b0, "R10");
        host_rev_req_n = 1'b1;
        wait_grant(1'b1, ok);
        chk(periph_req_n == 1'b1, "R2", "empty after abort run", periph_req_n, 1);

        repeat (4) @(negedge clk);
        chk(order_viol == 0, "R4", "oe/grant ordering violations", order_viol, 0);
        summary();
        $finish;
    end

endmodule